// File: doc/BRIEF.md
# Multichannel Delay Line Address Generator

This block produces the addresses for a sample memory that serves as a circular delay buffer for eight interleaved audio channels. Once per sample period a frame tick starts a burst of sixteen memory requests, one per clock: for each channel in ascending order a write of the incoming sample followed by a read of the delayed sample. Each request carries a valid strobe, a write/read flag, the channel number and the memory address.

The delay of a channel is a shared coarse term counted in blocks of 16 samples plus a per-channel fine term counted in single samples. A scale setting multiplies that sum by 1, 2 or 4 without touching the programmed values, and the product is clamped to the deepest delay the buffer can hold. Settings are written into shadow registers at any time and copied into the working set only when a frame starts, so every channel of a frame uses one consistent set.

Top module: `lsd_addr_gen`

## Requirements
- R1: While reset is asserted and after its release until the first frame tick, `mem_req_valid` is 0.
- R2: A frame tick seen while idle yields exactly 16 consecutive valid requests starting the next cycle; request k has channel k/2 and is a write (`mem_req_write`=1) for even k and a read for odd k; `mem_req_valid` is 0 in the cycle after the last.
- R3: The frame index starts at 0 in the first frame after reset, increases by one per frame and wraps modulo 2^FRAME_AW; a write address is frame*NCH + channel.
- R4: A read address is ((frame - D) mod 2^FRAME_AW)*NCH + channel, where D is that channel's effective delay.
- R5: Before scaling, D = 16*coarse + fine[channel].
- R6: Scale code 0 multiplies by 1, code 1 by 2, codes 2 and 3 by 4.
- R7: A scaled delay above 2^FRAME_AW-1 is replaced by 2^FRAME_AW-1.
- R8: With D = 0 a channel's read address equals the write address issued one cycle before.
- R9: A settings write, whether mid-frame or in the same cycle as the accepted tick, changes no address until the next accepted tick, when all channels switch together.
- R10: A frame tick arriving while a burst is in progress is ignored; the burst runs to its end unchanged.
- R11: Settings reset to 0. Select codes: 0..NCH-1 fine delay of that channel, NCH coarse delay, NCH+1 scale (low two data bits); other codes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | Start of a sample period |
| cfg_we | input | 1 | Settings write strobe |
| cfg_sel | input | SEL_W | Settings select code |
| cfg_wdata | input | FINE_W | Settings write data |
| mem_req_valid | output | 1 | Request present this cycle |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_ch | output | CH_W | Channel of the request |
| mem_req_addr | output | FRAME_AW+CH_W | Memory word address |

## Verification
Two functions meet in one cycle: a settings write and the frame tick that copies shadow values into the working set, and likewise a fresh tick against a burst still in progress. The bench drives a write in exactly the tick cycle and checks that the frame just started still uses the old delays while the following frame uses the new ones; it also raises a tick halfway through a burst and checks that the sixteen requests continue with unchanged addresses and no restart. Random writes at random request slots, checked against a bench model of shadow and working sets, cover the same collisions broadly.

// File: rtl/lsd_pkg.sv
package lsd_pkg;

  // Effective delay: (coarse*16 + fine) scaled by 1/2/4, clamped to max_d
  function automatic logic [31:0] lsd_eff_delay(input logic [31:0] coarse,
                                                input logic [31:0] fine,
                                                input logic [1:0]  scale,
                                                input logic [31:0] max_d);
    logic [35:0] base;
    logic [35:0] scaled;
    base = ({4'b0, coarse} << 4) + {4'b0, fine};
    unique case (scale)
      2'd0:    scaled = base;
      2'd1:    scaled = base << 1;
      default: scaled = base << 2;
    endcase
    if (scaled > {4'b0, max_d}) return max_d;
    return scaled[31:0];
  endfunction

endpackage

// File: rtl/lsd_cfg_regs.sv
module lsd_cfg_regs #(
  parameter int NCH      = 8,
  parameter int COARSE_W = 12,
  parameter int FINE_W   = 16,
  parameter int SEL_W    = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [SEL_W-1:0]              cfg_sel,
  input  logic [FINE_W-1:0]             cfg_wdata,
  input  logic                          frame_start,
  output logic [COARSE_W-1:0]           act_coarse,
  output logic [NCH-1:0][FINE_W-1:0]    act_fine,
  output logic [1:0]                    act_scale
);
  logic [COARSE_W-1:0] shd_coarse;
  logic [1:0]          shd_scale;
  logic                wr_coarse;
  logic                wr_scale;

  assign wr_coarse = cfg_we && (cfg_sel == SEL_W'(NCH));
  assign wr_scale  = cfg_we && (cfg_sel == SEL_W'(NCH + 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shd_coarse <= '0;
      shd_scale  <= '0;
      act_coarse <= '0;
      act_scale  <= '0;
    end else begin
      if (wr_coarse) shd_coarse <= cfg_wdata[COARSE_W-1:0];
      if (wr_scale)  shd_scale  <= cfg_wdata[1:0];
      if (frame_start) begin
        act_coarse <= shd_coarse;
        act_scale  <= shd_scale;
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_fine
    logic [FINE_W-1:0] shd_fine;
    logic              wr_fine;
    assign wr_fine = cfg_we && (cfg_sel == SEL_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shd_fine    <= '0;
        act_fine[g] <= '0;
      end else begin
        if (wr_fine)     shd_fine    <= cfg_wdata;
        if (frame_start) act_fine[g] <= shd_fine;
      end
    end
  end
endmodule

// File: rtl/lsd_seq.sv
module lsd_seq #(
  parameter int NCH      = 8,
  parameter int FRAME_AW = 16,
  localparam int CH_W    = $clog2(NCH),
  localparam int IDX_W   = CH_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_tick,
  output logic                busy,
  output logic                frame_start,
  output logic [IDX_W-1:0]    req_idx,
  output logic [FRAME_AW-1:0] wptr
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(2 * NCH - 1);

  assign frame_start = frame_tick && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      req_idx <= '0;
      wptr    <= '1;   // first frame lands on index 0
    end else if (frame_start) begin
      busy    <= 1'b1;
      req_idx <= '0;
      wptr    <= wptr + 1'b1;
    end else if (busy) begin
      if (req_idx == LAST_IDX) busy <= 1'b0;
      else                     req_idx <= req_idx + 1'b1;
    end
  end
endmodule

// File: rtl/lsd_delay_calc.sv
module lsd_delay_calc #(
  parameter int NCH      = 8,
  parameter int COARSE_W = 12,
  parameter int FINE_W   = 16,
  parameter int FRAME_AW = 16
) (
  input  logic [COARSE_W-1:0]        act_coarse,
  input  logic [NCH-1:0][FINE_W-1:0] act_fine,
  input  logic [1:0]                 act_scale,
  output logic [NCH-1:0][FRAME_AW-1:0] eff_delay
);
  import lsd_pkg::*;
  localparam logic [31:0] MAX_D = 32'((64'd1 << FRAME_AW) - 64'd1);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [31:0] full;
    assign full         = lsd_eff_delay(32'(act_coarse), 32'(act_fine[g]), act_scale, MAX_D);
    assign eff_delay[g] = full[FRAME_AW-1:0];
  end
endmodule

// File: rtl/lsd_addr_gen.sv
module lsd_addr_gen #(
  parameter int NCH      = 8,
  parameter int FRAME_AW = 16,
  parameter int COARSE_W = 12,
  parameter int FINE_W   = 16,
  localparam int CH_W    = $clog2(NCH),
  localparam int SEL_W   = $clog2(NCH + 2),
  localparam int ADDR_W  = FRAME_AW + CH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [FINE_W-1:0] cfg_wdata,
  output logic              mem_req_valid,
  output logic              mem_req_write,
  output logic [CH_W-1:0]   mem_req_ch,
  output logic [ADDR_W-1:0] mem_req_addr
);
  // named internal events for the checker
  logic                          seq_busy;
  logic                          frame_start;
  logic [CH_W:0]                 req_idx;
  logic [FRAME_AW-1:0]           wptr;
  logic [COARSE_W-1:0]           act_coarse;
  logic [NCH-1:0][FINE_W-1:0]    act_fine;
  logic [1:0]                    act_scale;
  logic [NCH-1:0][FRAME_AW-1:0]  eff_delay;
  logic [FRAME_AW-1:0]           cur_delay;
  logic [FRAME_AW-1:0]           rd_frame;

  lsd_seq #(.NCH(NCH), .FRAME_AW(FRAME_AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
    .busy(seq_busy), .frame_start(frame_start), .req_idx(req_idx), .wptr(wptr)
  );

  lsd_cfg_regs #(.NCH(NCH), .COARSE_W(COARSE_W), .FINE_W(FINE_W), .SEL_W(SEL_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .frame_start(frame_start), .act_coarse(act_coarse), .act_fine(act_fine),
    .act_scale(act_scale)
  );

  lsd_delay_calc #(.NCH(NCH), .COARSE_W(COARSE_W), .FINE_W(FINE_W), .FRAME_AW(FRAME_AW)) u_dly (
    .act_coarse(act_coarse), .act_fine(act_fine), .act_scale(act_scale), .eff_delay(eff_delay)
  );

  assign mem_req_valid = seq_busy;
  assign mem_req_write = ~req_idx[0];
  assign mem_req_ch    = req_idx[CH_W:1];
  assign cur_delay     = eff_delay[mem_req_ch];
  assign rd_frame      = wptr - cur_delay;
  assign mem_req_addr  = mem_req_write ? {wptr, mem_req_ch} : {rd_frame, mem_req_ch};
endmodule

// File: rtl/lsd_addr_gen_chk.sv
module lsd_addr_gen_chk #(
  parameter int NCH      = 8,
  parameter int FRAME_AW = 16,
  parameter int COARSE_W = 12,
  localparam int CH_W    = $clog2(NCH),
  localparam int ADDR_W  = FRAME_AW + CH_W
) (
  input logic                clk,
  input logic                rst_n,
  input logic                frame_tick,
  input logic                mem_req_valid,
  input logic                mem_req_write,
  input logic [CH_W-1:0]     mem_req_ch,
  input logic [ADDR_W-1:0]   mem_req_addr,
  input logic                seq_busy,
  input logic [FRAME_AW-1:0] cur_delay,
  input logic [COARSE_W-1:0] act_coarse,
  input logic [1:0]          act_scale
);
  // R2
  rd_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_write |->
      $past(mem_req_valid) && $past(mem_req_write) && mem_req_ch == $past(mem_req_ch));

  // R3
  addr_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[CH_W-1:0] == mem_req_ch);

  // R8
  zero_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_write && cur_delay == '0 |-> mem_req_addr == $past(mem_req_addr));

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |=> $stable(act_coarse) && $stable(act_scale));

  // R10
  busy_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick && mem_req_valid && !(mem_req_ch == CH_W'(NCH - 1) && !mem_req_write)
      |=> mem_req_valid && !(mem_req_ch == '0 && mem_req_write));
endmodule

bind lsd_addr_gen lsd_addr_gen_chk #(.NCH(NCH), .FRAME_AW(FRAME_AW), .COARSE_W(COARSE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .mem_req_valid(mem_req_valid),
  .mem_req_write(mem_req_write), .mem_req_ch(mem_req_ch), .mem_req_addr(mem_req_addr),
  .seq_busy(seq_busy), .cur_delay(cur_delay), .act_coarse(act_coarse), .act_scale(act_scale)
);

// File: tb/tb_lsd_addr_gen.sv
module tb_lsd_addr_gen;
  localparam int NCH = 8, FAW = 8, CW = 12, FW = 16;
  localparam int FMASK = (1 << FAW) - 1, MAXD = FMASK;

  logic clk = 0, rst_n = 0, frame_tick = 0, cfg_we = 0;
  logic [3:0]  cfg_sel = 0;
  logic [FW-1:0] cfg_wdata = 0;
  logic mem_req_valid, mem_req_write;
  logic [2:0] mem_req_ch;
  logic [FAW+2:0] mem_req_addr;

  lsd_addr_gen #(.NCH(NCH), .FRAME_AW(FAW), .COARSE_W(CW), .FINE_W(FW)) dut (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;
  int sh_fine[NCH], ac_fine[NCH];
  int sh_coarse = 0, ac_coarse = 0, sh_scale = 0, ac_scale = 0, wp = FMASK;

  function automatic int model_delay(int ch);
    int mult, v;
    mult = (ac_scale == 0) ? 1 : (ac_scale == 1) ? 2 : 4;   // R6
    v = (ac_coarse * 16 + ac_fine[ch]) * mult;                // R5
    return (v > MAXD) ? MAXD : v;                             // R7
  endfunction

  function automatic void model_write(int sel, int data);
    if (sel < NCH) sh_fine[sel] = data & 16'hFFFF;
    else if (sel == NCH) sh_coarse = data & 12'hFFF;
    else if (sel == NCH + 1) sh_scale = data & 3;
    // other codes: no effect (R11)
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_write(int sel, int data);
    cfg_we = 1; cfg_sel = 4'(sel); cfg_wdata = FW'(data);
    @(posedge clk); #1; cfg_we = 0;
    model_write(sel, data);
  endtask

  // one frame; optional write in tick cycle, optional mid-frame write, optional busy tick
  task automatic run_frame(bit tw, int tsel, int tdat, bit mw, int msel, int mdat, int mk, bit bt);
    frame_tick = 1;
    if (tw) begin cfg_we = 1; cfg_sel = 4'(tsel); cfg_wdata = FW'(tdat); end
    @(posedge clk); #1; frame_tick = 0; cfg_we = 0;
    for (int i = 0; i < NCH; i++) ac_fine[i] = sh_fine[i];
    ac_coarse = sh_coarse; ac_scale = sh_scale;
    if (tw) model_write(tsel, tdat);
    wp = (wp + 1) & FMASK;
    for (int k = 0; k < 2 * NCH; k++) begin
      int ch = k / 2;
      bit wr = (k % 2 == 0);
      int exp_addr = wr ? (wp * NCH + ch) : ((((wp - model_delay(ch)) & FMASK) * NCH) + ch);
      chk(mem_req_valid === 1'b1 && mem_req_write === wr && mem_req_ch === 3'(ch)
          && mem_req_addr === (FAW+3)'(exp_addr),
          wr ? "R2/R3 write req" : "R2/R4 read req", {mem_req_valid, mem_req_write, mem_req_addr},
          {1'b1, wr, (FAW+3)'(exp_addr)});
      if (mw && k == mk) begin
        cfg_we = 1; cfg_sel = 4'(msel); cfg_wdata = FW'(mdat);
        model_write(msel, mdat);
      end
      if (bt && k == 6) frame_tick = 1;   // R10
      @(posedge clk); #1; cfg_we = 0; frame_tick = 0;
    end
    chk(mem_req_valid === 1'b0, "R2 end of burst", mem_req_valid, 0);
    repeat (2) @(posedge clk);
    #1;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < NCH; i++) begin sh_fine[i] = 0; ac_fine[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    chk(mem_req_valid === 1'b0, "R1 in reset", mem_req_valid, 0);
    rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    chk(mem_req_valid === 1'b0, "R1 after reset", mem_req_valid, 0);

    // R11 reset values zero, R8 zero delay reads the just-written word, R3 frame 0
    run_frame(0, 0, 0, 0, 0, 0, 0, 0);
    // R5 coarse plus fine
    idle_write(NCH, 1); idle_write(3, 5);
    run_frame(0, 0, 0, 0, 0, 0, 0, 0);
    // R6 each scale code
    for (int s = 1; s < 4; s++) begin idle_write(NCH + 1, s); run_frame(0, 0, 0, 0, 0, 0, 0, 0); end
    // R7 clamp
    idle_write(NCH, 20); idle_write(0, 65535);
    run_frame(0, 0, 0, 0, 0, 0, 0, 0);
    // R9 write in tick cycle: old set still used this frame
    run_frame(1, NCH, 0, 0, 0, 0, 0, 0);
    run_frame(0, 0, 0, 0, 0, 0, 0, 0);
    // R9 mid-frame write
    run_frame(0, 0, 0, 1, 5, 7, 9, 0);
    run_frame(0, 0, 0, 0, 0, 0, 0, 0);
    // R10 tick during burst ignored
    run_frame(0, 0, 0, 0, 0, 0, 0, 1);
    // R11 unused select codes
    for (int s = NCH + 2; s < 16; s++) idle_write(s, 16'hFFFF);
    run_frame(0, 0, 0, 0, 0, 0, 0, 0);
    // random frames, wrap of frame index (R3)
    for (int f = 0; f < 300; f++) begin
      int sel = $urandom % 12;
      int dat = (sel == NCH) ? $urandom % 20 : (sel == NCH + 1) ? $urandom % 4 : $urandom % 96;
      int sel2 = $urandom % 12;
      int dat2 = $urandom % 64;
      if ($urandom % 3 == 0) idle_write($urandom % NCH, $urandom % 200);
      run_frame(($urandom % 4) == 0, sel, dat, ($urandom % 3) == 0, sel2, dat2,
                $urandom % 16, ($urandom % 8) == 0);
    end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule